// File: doc/BRIEF.md
# In-place exchange sorter

This block holds a small private memory of `DEPTH` words, each `WIDTH` bits wide, and sorts it into ascending unsigned order in place. It has two modes, selected by `sortMode`. While `sortMode` is low, the surrounding logic fills the memory through a simple write strobe and address. It can read any word back through a read strobe, and the word appears on `dataOut` one clock later.

Raising `sortMode` starts a nested-index compare-and-exchange pass over the memory. Register A holds the word at the outer index i. Register B holds the word at the inner index j, which always lies above i. When A is larger than B, the two words trade places and A is refreshed from position i. The memory has one port, so each read and each write takes its own controller state. When the last pair has been compared, `done` rises and stays high until `sortMode` falls. The memory can then be read out or reloaded.

Top module: `exch_sorter`

## Requirements
- R1: With `sortMode` low and the controller waiting, a high `wrInit` at a rising edge stores `dataIn` at address `hostAddr`.
- R2: With `sortMode` low and the controller waiting, a high `rdEn` at a rising edge puts the word at `hostAddr` on `dataOut` after that edge. If `wrInit` and `rdEn` are both high for the same address, `dataOut` shows the word as it was before that write.
- R3: After a sort, address 0 through `DEPTH-1` hold the original words in non-decreasing unsigned order, and as the same multiset.
- R4: Call the edge that first samples `sortMode` high edge 0. `done` is high exactly 2(DEPTH-1) + 4·P + 4·S cycles after edge 0. Here P = DEPTH(DEPTH-1)/2 is the number of compared pairs. S is the number of pairs, taken in order i ascending and then j ascending, where the current A is strictly greater than B. Equal words are never exchanged.
- R5: `done` stays high while `sortMode` is held high. It is low after the first rising edge that samples `sortMode` low while `done` is high.
- R6: `wrInit` and `rdEn` have no effect on the memory from the edge that samples `sortMode` high until `done` has been cleared. This includes an edge where the strobe and the rise of `sortMode` arrive together.
- R7: A high `rst` at a rising edge returns the controller to waiting with `done` low. It does not alter the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of control and index state |
| sortMode | input | 1 | 0 = load/read mode, 1 = sort request |
| wrInit | input | 1 | Host write strobe for load mode |
| rdEn | input | 1 | Host read strobe for load mode |
| hostAddr | input | ADDR_W | Host word address |
| dataIn | input | WIDTH | Host write data |
| dataOut | output | WIDTH | Registered memory read data |
| done | output | 1 | Sort complete; held until `sortMode` falls |

## Verification
Two functions can land on the same edge: a host access and the start of a sort. Both can also overlap the internal sort traffic. The bench raises `sortMode` on the same edge as a write of 0xFF to address 0, and later pulses a write and a read to address 1 in the middle of the sort. It judges both by checking that the sorted result is exactly the sorted original data and that the cycle count is unchanged. The other overlap is a host write and a host read to the same address on the same edge. The bench judges it by checking that the read returns the prior word, and that a following read returns the new one.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_I, S_LD_A, S_RD_J, S_LD_B, S_CMP,
    S_WR_I, S_WR_J, S_RD_I2, S_LD_A2, S_NEXT, S_DONE
  } sortState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic hostAcc;   // memory port belongs to the host this cycle
    logic memRd;     // internal read
    logic memWr;     // internal write
    logic addrSelJ;  // address mux: 0 = i, 1 = j
    logic wrSelB;    // write data mux: 0 = A, 1 = B
    logic loadA;
    logic loadB;
    logic iClr;
    logic iInc;
    logic jLoad;     // j <= i + 1
    logic jInc;
  } sortStrobe_t;

endpackage

// File: rtl/sorter_idx.sv
module sorter_idx #(
  parameter int W    = 2,
  parameter int LAST = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         inc,
  output logic [W-1:0] idx,
  output logic         atLast
);

  localparam logic [W-1:0] LAST_V = W'(LAST);

  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (clr)  idx <= '0;
    else if (load) idx <= loadVal;
    else if (inc)  idx <= idx + W'(1);
  end

  assign atLast = (idx == LAST_V);

endmodule

// File: rtl/sorter_dp.sv
module sorter_dp
  import sorter_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int WIDTH  = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  sortStrobe_t       strobe,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WIDTH-1:0]  hostData,
  output logic [WIDTH-1:0]  memQ,
  output logic              aGtB,
  output logic              iLast,
  output logic              jLast
);

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [WIDTH-1:0]  aReg, bReg;
  logic [ADDR_W-1:0] iIdx, jIdx;
  logic [ADDR_W-1:0] portAddr;
  logic [WIDTH-1:0]  portData;
  logic              portWe, portRe;

  sorter_idx #(.W(ADDR_W), .LAST(DEPTH-2)) i_iCnt (
    .clk(clk), .rst(rst), .clr(strobe.iClr), .load(1'b0), .loadVal('0),
    .inc(strobe.iInc), .idx(iIdx), .atLast(iLast)
  );

  sorter_idx #(.W(ADDR_W), .LAST(DEPTH-1)) i_jCnt (
    .clk(clk), .rst(rst), .clr(1'b0), .load(strobe.jLoad),
    .loadVal(iIdx + ADDR_W'(1)), .inc(strobe.jInc), .idx(jIdx), .atLast(jLast)
  );

  // address, data and enable muxes for the single port
  always_comb begin
    if (strobe.hostAcc) begin
      portAddr = hostAddr;
      portData = hostData;
      portWe   = hostWr;
      portRe   = hostRd;
    end else begin
      portAddr = strobe.addrSelJ ? jIdx : iIdx;
      portData = strobe.wrSelB ? bReg : aReg;
      portWe   = strobe.memWr;
      portRe   = strobe.memRd;
    end
  end

  always_ff @(posedge clk) begin
    if (portWe) mem[portAddr] <= portData;
    if (portRe) memQ <= mem[portAddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aReg <= '0;
      bReg <= '0;
    end else begin
      if (strobe.loadA) aReg <= memQ;
      if (strobe.loadB) bReg <= memQ;
    end
  end

  assign aGtB = aReg > bReg;

  // R3
  one_access_chk: assert property (@(posedge clk) disable iff (rst)
    !(strobe.memWr && strobe.memRd));

  // R3
  j_above_i_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.hostAcc && strobe.addrSelJ && (strobe.memRd || strobe.memWr)) |-> (jIdx > iIdx));

  // R4
  swap_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.memWr && !strobe.addrSelJ) |=> (strobe.memWr && strobe.addrSelJ && !strobe.wrSelB));

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe.hostAcc) |-> (iIdx <= ADDR_W'(DEPTH-2) && jIdx <= ADDR_W'(DEPTH-1)));

endmodule

// File: rtl/sorter_ctrl.sv
module sorter_ctrl
  import sorter_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sortMode,
  input  logic        aGtB,
  input  logic        iLast,
  input  logic        jLast,
  output sortStrobe_t strobe,
  output logic        done
);

  sortState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        strobe.hostAcc = !sortMode;
        if (sortMode) begin
          strobe.iClr = 1'b1;
          nextState   = S_RD_I;
        end
      end
      S_RD_I: begin
        strobe.memRd = 1'b1;
        nextState    = S_LD_A;
      end
      S_LD_A: begin
        strobe.loadA = 1'b1;
        strobe.jLoad = 1'b1;
        nextState    = S_RD_J;
      end
      S_RD_J: begin
        strobe.memRd    = 1'b1;
        strobe.addrSelJ = 1'b1;
        nextState       = S_LD_B;
      end
      S_LD_B: begin
        strobe.loadB = 1'b1;
        nextState    = S_CMP;
      end
      S_CMP: nextState = aGtB ? S_WR_I : S_NEXT;
      S_WR_I: begin
        strobe.memWr  = 1'b1;
        strobe.wrSelB = 1'b1;
        nextState     = S_WR_J;
      end
      S_WR_J: begin
        strobe.memWr    = 1'b1;
        strobe.addrSelJ = 1'b1;
        nextState       = S_RD_I2;
      end
      S_RD_I2: begin
        strobe.memRd = 1'b1;
        nextState    = S_LD_A2;
      end
      S_LD_A2: begin
        strobe.loadA = 1'b1;
        nextState    = S_NEXT;
      end
      S_NEXT: begin
        if (!jLast) begin
          strobe.jInc = 1'b1;
          nextState   = S_RD_J;
        end else if (!iLast) begin
          strobe.iInc = 1'b1;
          nextState   = S_RD_I;
        end else begin
          nextState = S_DONE;
        end
      end
      S_DONE: if (!sortMode) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign done = (state == S_DONE);

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && sortMode) |=> done);

  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !sortMode) |=> !done);

  // R6
  host_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (sortMode || done) |-> !strobe.hostAcc);

endmodule

// File: rtl/exch_sorter.sv
module exch_sorter
  import sorter_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int WIDTH  = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sortMode,
  input  logic              wrInit,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WIDTH-1:0]  dataIn,
  output logic [WIDTH-1:0]  dataOut,
  output logic              done
);

  sortStrobe_t strobe;
  logic        aGtB, iLast, jLast;

  sorter_ctrl i_ctrl (
    .clk(clk), .rst(rst), .sortMode(sortMode), .aGtB(aGtB),
    .iLast(iLast), .jLast(jLast), .strobe(strobe), .done(done)
  );

  sorter_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .hostWr(wrInit), .hostRd(rdEn),
    .hostAddr(hostAddr), .hostData(dataIn), .memQ(dataOut),
    .aGtB(aGtB), .iLast(iLast), .jLast(jLast)
  );

endmodule

// File: tb/test_exch_sorter.sv
module test_exch_sorter;

  localparam int K = 4;
  localparam int W = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sortMode = 1'b0;
  logic          wrInit = 1'b0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [W-1:0]  dataIn = '0;
  logic [W-1:0]  dataOut;
  logic          done;

  int compared = 0;
  int mismatched = 0;
  logic [W-1:0] expArr [K];
  int expSwaps;

  always #10 clk = ~clk;  // 50 MHz

  exch_sorter #(.DEPTH(K), .WIDTH(W)) i_exch_sorter (
    .clk(clk), .rst(rst), .sortMode(sortMode), .wrInit(wrInit), .rdEn(rdEn),
    .hostAddr(hostAddr), .dataIn(dataIn), .dataOut(dataOut), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wrInit = 1'b1; hostAddr = a; dataIn = d;
    @(negedge clk);
    wrInit = 1'b0;
  endtask

  task automatic hostRead(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    rdEn = 1'b1; hostAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = dataOut;
  endtask

  // bench model of the exchange procedure: sorts expArr, counts swaps
  task automatic modelSort();
    logic [W-1:0] t;
    expSwaps = 0;
    for (int i = 0; i < K-1; i++)
      for (int j = i+1; j < K; j++)
        if (expArr[i] > expArr[j]) begin
          t = expArr[i]; expArr[i] = expArr[j]; expArr[j] = t;
          expSwaps++;
        end
  endtask

  task automatic runCase(input logic [31:0] pv, input bit poke, input int holdCycles);
    int cnt;
    int expCycles;
    logic [W-1:0] rd;
    for (int a = 0; a < K; a++) begin
      expArr[a] = pv[a*W +: W];
      hostWrite(AW'(a), pv[a*W +: W]);
    end
    modelSort();
    expCycles = 2*(K-1) + 4*(K*(K-1)/2) + 4*expSwaps;
    @(negedge clk);
    sortMode = 1'b1;
    if (poke) begin  // R6: strobe on the same edge as the sort request
      wrInit = 1'b1; hostAddr = '0; dataIn = 8'hFF;
    end
    cnt = 0;
    while (cnt < 1000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      wrInit = 1'b0; rdEn = 1'b0;
      if (poke && cnt == 3) begin
        wrInit = 1'b1; rdEn = 1'b1; hostAddr = 2'd1; dataIn = 8'hEE;
      end
      if (done) break;
    end
    wrInit = 1'b0; rdEn = 1'b0;
    // R4: exact sort duration
    chk("R4 cycles", cnt - 1, expCycles);
    for (int h = 0; h < holdCycles; h++) @(negedge clk);
    // R5: done held while sortMode high
    chk("R5 hold", done, 1);
    sortMode = 1'b0;
    @(negedge clk);
    chk("R5 clear", done, 0);
    for (int a = 0; a < K; a++) begin
      hostRead(AW'(a), rd);
      chk(poke ? "R6 result" : "R3 result", rd, expArr[a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [W-1:0] rd;
    logic [31:0] lfsr;
    logic [W-1:0] vals [4];
    vals[0] = 8'h00; vals[1] = 8'h7F; vals[2] = 8'h80; vals[3] = 8'hFF;

    repeat (3) @(negedge clk);
    chk("R7 reset done", done, 0);
    rst = 1'b0;

    // R1 / R2: load and read back
    for (int a = 0; a < K; a++) hostWrite(AW'(a), W'(8'h30 + a));
    for (int a = 0; a < K; a++) begin
      hostRead(AW'(a), rd);
      chk("R1 readback", rd, 8'h30 + a);
    end

    // R2: same-edge write and read return the prior word
    @(negedge clk);
    wrInit = 1'b1; rdEn = 1'b1; hostAddr = 2'd2; dataIn = 8'h22;
    @(negedge clk);
    wrInit = 1'b0; rdEn = 1'b0;
    chk("R2 read-before-write", dataOut, 8'h32);
    hostRead(2'd2, rd);
    chk("R2 new word", rd, 8'h22);

    // R7: reset keeps memory
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk("R7 done after reset", done, 0);
    hostRead(2'd3, rd);
    chk("R7 memory kept", rd, 8'h33);
    hostRead(2'd2, rd);
    chk("R7 memory kept", rd, 8'h22);

    // R4: all equal words, no exchange
    runCase(32'h55555555, 1'b0, 4);
    // R3: sorted and reverse-sorted inputs
    runCase(32'hFF80_7F00, 1'b0, 1);
    runCase(32'h007F_80FF, 1'b0, 1);
    // R3: duplicates
    runCase(32'h1010_0101, 1'b0, 1);

    // R3 / R4: every ordering of four distinct extreme values
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d)
              runCase({vals[d], vals[c], vals[b], vals[a]}, 1'b0, 0);

    // R6: host strobes during the sort and at its start are dropped
    runCase(32'h0A03_C107, 1'b1, 0);
    runCase(32'h0000_0001, 1'b1, 2);

    // R3 / R4: pseudo-random sets
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      runCase(lfsr, n[0], 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule